// File: doc/BRIEF.md
# Test Environment Control Register Bank

A byte-wide, I/O-mapped register bank that a processor under test uses to talk to its simulation harness. It occupies the 32-port window from 0x80 to 0x9F. Accesses outside that window are ignored. The bank has five features:

- a character collector that hands a finished text line to the harness;
- a watchdog counter with a programmable 16-bit limit and a sticky error flag;
- a one-shot countdown that pulls an active-low interrupt;
- a modulo-256 checksum that can be preset and accumulated;
- a counter that advances on every read.

Software drives the bank with single-cycle read and write strobes, an 8-bit port address and 8-bit data. Read data is combinational while the address is presented. The side effect of a read (the counter advancing) takes place at the clock edge that ends the access.

Top module: `tenv_ctl_bank`

## Requirements
- R1: Only addresses with bits [7:5] = 3'b100 (0x80–0x9F) are decoded. Writes outside that window change no state, and reads outside it return 0xFF.
- R2: Each byte other than 0x0A written to port 0x81 is stored at the next free position of a 64-entry buffer, starting at position 0, with position n at msg_text[8n+7:8n]. Bytes beyond the 64th are dropped.
- R3: Writing 0x0A to port 0x81 raises line_rdy for exactly the one clock after the write edge. In that same clock, line_len holds the number of stored characters. The newline itself is not stored, and the character count restarts at zero.
- R4: In port 0x82, bit 0 enables the watchdog counter and a 1 in bit 1 clears the counter. The watchdog is enabled after reset. Reading 0x82 returns 0x00 or 0x01, the current enable bit.
- R5: The watchdog limit is written as its low byte at 0x83 and its high byte at 0x84. Both bytes read back from the same ports, and the limit resets to 0xFFFF.
- R6: While enabled, the watchdog counter advances once per clock. If it is cleared at write edge E and the limit is L, tmo_err rises at edge E+L+1. From then on tmo_err stays high until reset, and the counter stops.
- R7: Writing a nonzero value N to port 0x90 at edge E drives irq_n low at edge E+N. irq_n then stays low until port 0x90 is written again.
- R8: Writing 0 to port 0x90 sets irq_n high and cancels any pending countdown.
- R9: Writing port 0x91 loads the checksum. Reading port 0x91 returns the checksum.
- R10: Writing a byte to port 0x92 adds it to the checksum modulo 256.
- R11: Reading port 0x93 returns the counter value and then increments it, wrapping from 0xFF to 0x00. Writing port 0x93 loads a new value.
- R12: Reads inside the window that do not fall on 0x82, 0x83, 0x84, 0x91 or 0x93 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the presented address |
| irq_n | output | 1 | Active-low interrupt from the countdown |
| tmo_err | output | 1 | Sticky watchdog expiry flag |
| line_rdy | output | 1 | One-clock pulse when a line is complete |
| line_len | output | 7 | Character count of the completed line |
| msg_text | output | 512 | Character buffer, position n at bits 8n+7:8n |

## Verification
The assertions check several rules on every cycle:
- tmo_err never falls once it has risen;
- irq_n never rises without a write to 0x90;
- every line_rdy pulse follows a newline write;
- the character count stays within the buffer;
- unmapped reads inside the window return 0xFF;
- each read of 0x93 advances the counter by one.

Only the bench scenarios can show the exact timing of the two timers. For the watchdog this is the edge on which tmo_err rises. For the interrupt countdown it is the edge on which irq_n falls, and the fact that a countdown cancelled by writing 0 never fires. The same holds for the arithmetic of the checksum, for the buffer contents, for the drop of overflow characters, and for the line length that is captured.

// File: rtl/tenv_ctl_bank.sv
module tenv_ctl_bank #(
  parameter int          MSG_DEPTH = 64,
  parameter logic [15:0] TMO_INIT  = 16'hFFFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_rd,
  input  logic                   io_wr,
  input  logic [7:0]             io_addr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   irq_n,
  output logic                   tmo_err,
  output logic                   line_rdy,
  output logic [$clog2(MSG_DEPTH+1)-1:0] line_len,
  output logic [MSG_DEPTH*8-1:0] msg_text
);
  localparam int LW = $clog2(MSG_DEPTH+1);
  localparam int IW = $clog2(MSG_DEPTH);
  localparam logic [4:0] O_MSG  = 5'h01;
  localparam logic [4:0] O_TCTL = 5'h02;
  localparam logic [4:0] O_TLO  = 5'h03;
  localparam logic [4:0] O_THI  = 5'h04;
  localparam logic [4:0] O_CD   = 5'h10;
  localparam logic [4:0] O_CSUM = 5'h11;
  localparam logic [4:0] O_ACC  = 5'h12;
  localparam logic [4:0] O_INC  = 5'h13;

  wire       hit   = (io_addr[7:5] == 3'b100);
  wire [4:0] ofs   = io_addr[4:0];
  wire       wr_ok = io_wr & hit;
  wire       rd_ok = io_rd & hit;

  wire wr_msg  = wr_ok && ofs == O_MSG;
  wire wr_tctl = wr_ok && ofs == O_TCTL;
  wire wr_tlo  = wr_ok && ofs == O_TLO;
  wire wr_thi  = wr_ok && ofs == O_THI;
  wire wr_cd   = wr_ok && ofs == O_CD;
  wire wr_csum = wr_ok && ofs == O_CSUM;
  wire wr_acc  = wr_ok && ofs == O_ACC;
  wire wr_inc  = wr_ok && ofs == O_INC;
  wire rd_inc  = rd_ok && ofs == O_INC;
  wire nl      = wr_msg && io_wdata == 8'h0A;

  logic [7:0]    msg_mem [MSG_DEPTH];
  logic [LW-1:0] msg_cnt;
  wire           msg_room = msg_cnt < LW'(MSG_DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_cnt  <= '0;
      line_rdy <= 1'b0;
      line_len <= '0;
    end else begin
      line_rdy <= nl;
      if (nl) begin
        line_len <= msg_cnt;
        msg_cnt  <= '0;
      end else if (wr_msg && msg_room) begin
        msg_cnt <= msg_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_msg && !nl && msg_room) msg_mem[msg_cnt[IW-1:0]] <= io_wdata;
  end

  for (genvar g = 0; g < MSG_DEPTH; g++) begin : g_txt
    assign msg_text[g*8 +: 8] = msg_mem[g];
  end

  logic        tmo_en;
  logic [15:0] tmo_cnt;
  logic [15:0] tmo_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_en  <= 1'b1;
      tmo_cnt <= '0;
      tmo_lim <= TMO_INIT;
      tmo_err <= 1'b0;
    end else begin
      if (wr_tlo) tmo_lim[7:0]  <= io_wdata;
      if (wr_thi) tmo_lim[15:8] <= io_wdata;
      if (wr_tctl) begin
        tmo_en <= io_wdata[0];
        if (io_wdata[1]) tmo_cnt <= '0;
      end else if (tmo_en && !tmo_err) begin
        if (tmo_cnt == tmo_lim) tmo_err <= 1'b1;
        else                    tmo_cnt <= tmo_cnt + 1'b1;
      end
    end
  end

  logic [7:0] cd_val;
  logic       cd_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_val <= '0;
      cd_run <= 1'b0;
      irq_n  <= 1'b1;
    end else if (wr_cd) begin
      cd_val <= io_wdata;
      cd_run <= io_wdata != 8'h00;
      irq_n  <= 1'b1;
    end else if (cd_run) begin
      if (cd_val == 8'd1) begin
        irq_n  <= 1'b0;
        cd_run <= 1'b0;
      end else begin
        cd_val <= cd_val - 1'b1;
      end
    end
  end

  logic [7:0] csum;
  logic [7:0] inc_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csum    <= '0;
      inc_val <= '0;
    end else begin
      if (wr_csum)     csum <= io_wdata;
      else if (wr_acc) csum <= csum + io_wdata;
      if (wr_inc)      inc_val <= io_wdata;
      else if (rd_inc) inc_val <= inc_val + 1'b1;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (hit) begin
      case (ofs)
        O_TCTL:  io_rdata = {7'b0, tmo_en};
        O_TLO:   io_rdata = tmo_lim[7:0];
        O_THI:   io_rdata = tmo_lim[15:8];
        O_CSUM:  io_rdata = csum;
        O_INC:   io_rdata = inc_val;
        default: io_rdata = 8'hFF;
      endcase
    end
  end
endmodule

module tenv_ctl_bank_chk #(
  parameter int MSG_DEPTH = 64,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_rd,
  input logic          io_wr,
  input logic [7:0]    io_addr,
  input logic [7:0]    io_wdata,
  input logic [7:0]    io_rdata,
  input logic          irq_n,
  input logic          tmo_err,
  input logic          line_rdy,
  input logic [LW-1:0] msg_cnt,
  input logic [7:0]    inc_val
);
  wire in_win  = io_addr[7:5] == 3'b100;
  wire mapped  = io_addr[4:0] inside {5'h02, 5'h03, 5'h04, 5'h11, 5'h13};

  // R6
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(io_wr && io_addr == 8'h90)) |=> !irq_n);

  // R3
  line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_rdy |-> $past(io_wr && io_addr == 8'h81 && io_wdata == 8'h0A));

  // R2
  msg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_cnt <= LW'(MSG_DEPTH));

  // R12
  unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !mapped) |-> io_rdata == 8'hFF);

  // R11
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr == 8'h93) |=> inc_val == 8'($past(inc_val) + 8'd1));
endmodule

bind tenv_ctl_bank tenv_ctl_bank_chk #(.MSG_DEPTH(MSG_DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_n(irq_n), .tmo_err(tmo_err),
  .line_rdy(line_rdy), .msg_cnt(msg_cnt), .inc_val(inc_val)
);

// File: tb/tenv_ctl_bank_tb_top.sv
module tenv_ctl_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic [7:0] io_rdata;
  logic irq_n, tmo_err, line_rdy;
  logic [6:0] line_len;
  logic [511:0] msg_text;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  tenv_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq_n(irq_n), .tmo_err(tmo_err),
    .line_rdy(line_rdy), .line_len(line_len), .msg_text(msg_text)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    #5;
    if (io_rd && exp_q.size() > 0) chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R7 reset irq_n", irq_n, 1);
    chk("R6 reset tmo_err", tmo_err, 0);
    chk("R3 reset line_rdy", line_rdy, 0);
    rd(8'h82, 8'h01, "R4 enabled after reset");
    rd(8'h83, 8'hFF, "R5 limit low reset");
    rd(8'h84, 8'hFF, "R5 limit high reset");
    wr(8'h82, 8'h00);
    rd(8'h82, 8'h00, "R4 disable readback");

    // R12 / R1
    rd(8'h80, 8'hFF, "R12 read 0x80");
    rd(8'h85, 8'hFF, "R12 read 0x85");
    rd(8'h9F, 8'hFF, "R12 read 0x9F");
    rd(8'h13, 8'hFF, "R1 read outside window");

    // R9 R10
    wr(8'h91, 8'hF0);
    rd(8'h91, 8'hF0, "R9 checksum load");
    wr(8'h92, 8'h20);
    rd(8'h91, 8'h10, "R10 accumulate wrap");
    wr(8'h92, 8'h05);
    rd(8'h91, 8'h15, "R10 accumulate");
    wr(8'h11, 8'h77);
    rd(8'h91, 8'h15, "R1 write outside window ignored");

    // R11
    wr(8'h93, 8'hFE);
    rd(8'h93, 8'hFE, "R11 first read");
    rd(8'h93, 8'hFF, "R11 second read");
    rd(8'h93, 8'h00, "R11 wrap");

    // R2 R3
    wr(8'h81, "H");
    wr(8'h81, "i");
    wr(8'h81, 8'h0A);
    chk("R3 line_rdy pulse", line_rdy, 1);
    chk("R3 line_len", line_len, 2);
    chk("R2 char 0", msg_text[7:0], "H");
    chk("R2 char 1", msg_text[15:8], "i");
    @(negedge clk);
    chk("R3 pulse one clock", line_rdy, 0);
    for (int i = 0; i < 66; i++) wr(8'h81, 8'(i + 8'h20));
    wr(8'h81, 8'h0A);
    chk("R3 overflow line_rdy", line_rdy, 1);
    chk("R2 overflow length capped", line_len, 64);
    chk("R2 last stored char", msg_text[511:504], 8'h20 + 8'd63);
    chk("R2 first char", msg_text[7:0], 8'h20);
    wr(8'h81, "z");
    wr(8'h81, 8'h0A);
    chk("R3 count restarted", line_len, 1);

    // R7 R8
    wr(8'h90, 8'd5);
    repeat (4) @(negedge clk);
    chk("R7 irq not yet", irq_n, 1);
    @(negedge clk);
    chk("R7 irq asserted", irq_n, 0);
    repeat (10) @(negedge clk);
    chk("R7 irq held", irq_n, 0);
    wr(8'h90, 8'd0);
    chk("R8 zero write releases", irq_n, 1);
    wr(8'h90, 8'd3);
    wr(8'h90, 8'd0);
    repeat (6) @(negedge clk);
    chk("R8 cancelled countdown", irq_n, 1);

    // R5 R6
    wr(8'h83, 8'd20);
    wr(8'h84, 8'd0);
    rd(8'h83, 8'd20, "R5 limit low readback");
    rd(8'h84, 8'd0, "R5 limit high readback");
    wr(8'h82, 8'h03);
    repeat (20) @(negedge clk);
    chk("R6 no error at limit edge", tmo_err, 0);
    @(negedge clk);
    chk("R6 error raised", tmo_err, 1);
    wr(8'h82, 8'h02);
    repeat (3) @(negedge clk);
    chk("R6 error sticky", tmo_err, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule